// File: doc/BRIEF.md
# Keypad Event Queue

This block buffers keypad events between the key-event source and a command-driven read port. Each event is one byte: the low seven bits carry the key code and the top bit is set for a press and clear for a release. The queue has sixteen slots arranged as a ring, tracked by a head index and an occupancy level that both wrap modulo the depth.

The reader has two modes. A pop read moves the head forward by one slot, lowers the level by one and returns the byte at the new head. A peek read takes a byte offset and returns the entry that many slots past the head, without changing the queue. Each accepted event produces a one-cycle keypad request toward the status logic.

An event that arrives when all sixteen slots are in use is dropped and produces a one-cycle overflow request. From then on the queue discards new events silently until the error is acknowledged. A clear from a configuration write empties the queue and drops that discard state.

Top module: `key_event_queue`

## Requirements
- R1: After reset, level_o is 0, rd_data_o is 0x00, kp_irq_o and ovf_req_o are low and ovf_lock_o is low.
- R2: A stored event byte is {key_down_i, key_code_i}: bit 7 is 1 for a press and 0 for a release, and bits 6:0 hold the code. A peek at offset 0 returns the oldest queued event.
- R3: A push that arrives with level_o equal to 16 is dropped. One cycle later ovf_req_o pulses for one cycle, ovf_lock_o is high, and level_o has not risen.
- R4: While ovf_lock_o is high, a push has no effect: no kp_irq_o, no ovf_req_o, and level_o does not rise. A pulse on err_clr_i lowers ovf_lock_o on the next cycle, and later pushes are accepted again.
- R5: Each accepted push raises kp_irq_o for exactly one cycle, on the cycle after the push, and raises level_o by one.
- R6: A pop with level_o above 0 lowers level_o by one, moves the head forward by one slot, and on the next cycle puts on rd_data_o the byte at the new head position.
- R7: A peek (peek_i high, pop_i low) at offset n returns the entry at head+n modulo 16 when n is below level_o, and 0x00 otherwise. The level is not changed. The result appears on rd_data_o one cycle later.
- R8: clr_i sets the head and the level to zero, lowers ovf_lock_o and loads 0x00 into rd_data_o. It overrides any push, pop or peek in the same cycle.
- R9: A pop with level_o at 0 returns 0x00 and leaves the level and the head unchanged.
- R10: A push and a pop in the same cycle are both honoured, so the level stays the same. The pop returns memory contents from before that cycle's write. Whether the push is accepted is decided on the level before the pop.
- R11: The write position (head plus level) and the head both wrap modulo 16 across long mixed sequences of pushes, pops and peeks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Clear from configuration write: empties queue, releases lock |
| err_clr_i | input | 1 | Acknowledge of the overflow error; releases the discard lock |
| push_i | input | 1 | Key event strobe |
| key_code_i | input | 7 | Key code of the event |
| key_down_i | input | 1 | 1 = pressed, 0 = released |
| pop_i | input | 1 | Consuming read of one byte |
| peek_i | input | 1 | Non-consuming read at an offset |
| peek_ofs_i | input | 8 | Byte offset for a peek read |
| rd_data_o | output | 8 | Read result, valid the cycle after a read |
| kp_irq_o | output | 1 | One-cycle keypad-event request |
| ovf_req_o | output | 1 | One-cycle overflow-error request |
| ovf_lock_o | output | 1 | High while new events are being discarded |
| level_o | output | 5 | Number of queued events, 0 to 16 |

## Verification
The hardest case to reach is the discard lock when the head has already moved off slot zero. To get there, the stimulus first consumes part of the queue so the head sits mid-ring, then refills all sixteen slots so the write position wraps, and then pushes again. Further pushes and a pop are issued while the lock is held, and the level is checked to show nothing got in. The bench then acknowledges the error, confirms a push is taken again, and runs a long arithmetic mix of pushes, pops, peeks and simultaneous push-pop cycles against its own model of the ring.

// File: rtl/kq_pkg.sv
package kq_pkg;

  typedef logic [7:0] kq_byte_t;

  // event byte: press flag on top, key code below
  function automatic kq_byte_t kq_pack(input logic down, input logic [6:0] code);
    return {down, code};
  endfunction

  // an offset names a live entry only below the current level
  function automatic logic kq_in_range(input logic [31:0] ofs, input logic [31:0] lvl);
    return ofs < lvl;
  endfunction

endpackage

// File: rtl/kq_ctrl.sv
module kq_ctrl #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             err_clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W:0]   level_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             accept_o,
  output logic             ovf_hit_o,
  output logic             pop_fire_o,
  output logic             lock_o,
  output logic             kp_irq_o,
  output logic             ovf_req_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W:0] FULL_LVL = (IDX_W+1)'(DEPTH);

  logic [IDX_W-1:0] head_q;
  logic [IDX_W:0]   lvl_q;
  logic             lock_q;
  logic             irq_q;
  logic             ovf_q;
  logic             full_w;
  logic             gate_w;
  logic [IDX_W:0]   lvl_d;

  assign full_w     = (lvl_q == FULL_LVL);
  assign gate_w     = push_i & ~clr_i & ~lock_q;
  assign accept_o   = gate_w & ~full_w;
  assign ovf_hit_o  = gate_w & full_w;
  assign pop_fire_o = pop_i & ~clr_i & (lvl_q != '0);
  // write slot sits level entries past the head, wrapping in IDX_W bits
  assign wr_idx_o   = head_q + lvl_q[IDX_W-1:0];

  always_comb begin
    lvl_d = lvl_q + (IDX_W+1)'(accept_o) - (IDX_W+1)'(pop_fire_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      lvl_q  <= '0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      head_q <= '0;
      lvl_q  <= '0;
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      head_q <= head_q + IDX_W'(pop_fire_o);
      lvl_q  <= lvl_d;
      lock_q <= ovf_hit_o | (lock_q & ~err_clr_i);
      irq_q  <= accept_o;
      ovf_q  <= ovf_hit_o;
    end
  end

  assign head_o    = head_q;
  assign level_o   = lvl_q;
  assign lock_o    = lock_q;
  assign kp_irq_o  = irq_q;
  assign ovf_req_o = ovf_q;
endmodule

// File: rtl/kq_store.sv
module kq_store #(
  parameter int IDX_W = 4,
  parameter int NRD   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [7:0]                wr_byte_i,
  input  logic [NRD-1:0][IDX_W-1:0] rd_idx_i,
  output logic [NRD-1:0][7:0]       rd_byte_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] slot_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (wr_en_i) begin
      slot_q[wr_idx_i] <= wr_byte_i;
    end
  end

  // independent combinational read ports, all see pre-write contents
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_byte_o[g] = slot_q[rd_idx_i[g]];
  end
endmodule

// File: rtl/kq_read.sv
module kq_read
  import kq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             pop_i,
  input  logic             pop_fire_i,
  input  logic             peek_i,
  input  logic [OFS_W-1:0] peek_ofs_i,
  input  logic [IDX_W-1:0] head_i,
  input  logic [IDX_W:0]   level_i,
  input  kq_byte_t         pop_byte_i,
  input  kq_byte_t         peek_byte_i,
  output logic [IDX_W-1:0] pop_idx_o,
  output logic [IDX_W-1:0] peek_idx_o,
  output logic             peek_hit_o,
  output kq_byte_t         rd_data_o
);
  kq_byte_t rd_q;
  kq_byte_t rd_d;

  assign pop_idx_o  = head_i + IDX_W'(1);
  assign peek_idx_o = head_i + peek_ofs_i[IDX_W-1:0];
  assign peek_hit_o = peek_i & ~pop_i & ~clr_i
                    & kq_in_range(32'(peek_ofs_i), 32'(level_i));

  always_comb begin
    rd_d = rd_q;
    if (clr_i)           rd_d = '0;
    else if (pop_i)      rd_d = pop_fire_i ? pop_byte_i : '0;
    else if (peek_i)     rd_d = peek_hit_o ? peek_byte_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
  import kq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             err_clr_i,
  input  logic             push_i,
  input  logic [6:0]       key_code_i,
  input  logic             key_down_i,
  input  logic             pop_i,
  input  logic             peek_i,
  input  logic [OFS_W-1:0] peek_ofs_i,
  output logic [7:0]       rd_data_o,
  output logic             kp_irq_o,
  output logic             ovf_req_o,
  output logic             ovf_lock_o,
  output logic [IDX_W:0]   level_o
);
  localparam int NRD = 2;

  // named internal events, visible to the bound checker
  logic                      ev_accept;
  logic                      ev_overflow;
  logic                      ev_pop;
  logic                      ev_peek_hit;
  logic [IDX_W-1:0]          head_w;
  logic [IDX_W-1:0]          wr_idx_w;
  logic [IDX_W-1:0]          pop_idx_w;
  logic [IDX_W-1:0]          peek_idx_w;
  logic [NRD-1:0][IDX_W-1:0] rd_idx_w;
  logic [NRD-1:0][7:0]       rd_byte_w;
  kq_byte_t                  ev_byte;

  assign ev_byte = kq_pack(key_down_i, key_code_i);

  kq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .err_clr_i  (err_clr_i),
    .push_i     (push_i),
    .pop_i      (pop_i),
    .head_o     (head_w),
    .level_o    (level_o),
    .wr_idx_o   (wr_idx_w),
    .accept_o   (ev_accept),
    .ovf_hit_o  (ev_overflow),
    .pop_fire_o (ev_pop),
    .lock_o     (ovf_lock_o),
    .kp_irq_o   (kp_irq_o),
    .ovf_req_o  (ovf_req_o)
  );

  assign rd_idx_w[0] = pop_idx_w;
  assign rd_idx_w[1] = peek_idx_w;

  kq_store #(.IDX_W(IDX_W), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (ev_accept),
    .wr_idx_i  (wr_idx_w),
    .wr_byte_i (ev_byte),
    .rd_idx_i  (rd_idx_w),
    .rd_byte_o (rd_byte_w)
  );

  kq_read #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u_read (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (clr_i),
    .pop_i       (pop_i),
    .pop_fire_i  (ev_pop),
    .peek_i      (peek_i),
    .peek_ofs_i  (peek_ofs_i),
    .head_i      (head_w),
    .level_i     (level_o),
    .pop_byte_i  (rd_byte_w[0]),
    .peek_byte_i (rd_byte_w[1]),
    .pop_idx_o   (pop_idx_w),
    .peek_idx_o  (peek_idx_w),
    .peek_hit_o  (ev_peek_hit),
    .rd_data_o   (rd_data_o)
  );
endmodule

// File: rtl/kq_checker.sv
module kq_checker #(
  parameter int IDX_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           clr_i,
  input logic           err_clr_i,
  input logic           push_i,
  input logic           pop_i,
  input logic           peek_i,
  input logic [7:0]     rd_data_o,
  input logic           kp_irq_o,
  input logic           ovf_req_o,
  input logic           ovf_lock_o,
  input logic [IDX_W:0] level_o,
  input logic           ev_accept,
  input logic           ev_peek_hit
);
  localparam logic [IDX_W:0] FULL_LVL = (IDX_W+1)'(1 << IDX_W);

  always_comb begin
    if (rst_n) begin
      assert_level_bound_R11: assert (level_o <= FULL_LVL);
    end
  end

  assert_irq_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> kp_irq_o && !ovf_req_o);

  assert_full_push_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !clr_i && !ovf_lock_o && level_o == FULL_LVL) |=> (ovf_req_o && ovf_lock_o));

  assert_locked_discard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lock_o && push_i && !pop_i && !clr_i) |=> (!kp_irq_o && !ovf_req_o && $stable(level_o)));

  assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (level_o == '0 && !ovf_lock_o && rd_data_o == 8'h00));

  assert_empty_pop_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !push_i && !clr_i && level_o == '0) |=> (rd_data_o == 8'h00 && level_o == '0));

  assert_push_pop_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !clr_i && !ovf_lock_o && level_o != '0 && level_o != FULL_LVL)
      |=> $stable(level_o));

  assert_peek_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_i && !pop_i && !clr_i && !ev_peek_hit) |=> rd_data_o == 8'h00);

  assert_lock_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_lock_o && err_clr_i && !push_i) |=> !ovf_lock_o);
endmodule

bind key_event_queue kq_checker #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .err_clr_i   (err_clr_i),
  .push_i      (push_i),
  .pop_i       (pop_i),
  .peek_i      (peek_i),
  .rd_data_o   (rd_data_o),
  .kp_irq_o    (kp_irq_o),
  .ovf_req_o   (ovf_req_o),
  .ovf_lock_o  (ovf_lock_o),
  .level_o     (level_o),
  .ev_accept   (ev_accept),
  .ev_peek_hit (ev_peek_hit)
);

// File: tb/sim_key_event_queue.sv
module sim_key_event_queue;
  localparam int IDX_W = 4;
  localparam int OFS_W = 8;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             clr_i, err_clr_i, push_i, key_down_i, pop_i, peek_i;
  logic [6:0]       key_code_i;
  logic [OFS_W-1:0] peek_ofs_i;
  logic [7:0]       rd_data_o;
  logic             kp_irq_o, ovf_req_o, ovf_lock_o;
  logic [IDX_W:0]   level_o;

  always #5 clk = ~clk;

  key_event_queue #(.IDX_W(IDX_W), .OFS_W(OFS_W)) u0 (.*);

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  // reference ring, kept from the requirements alone
  logic [7:0] mdl [DEPTH];
  int         m_head = 0;
  int         m_lvl  = 0;
  bit         m_lock = 1'b0;
  logic [7:0] m_rd   = 8'h00;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic step(input bit psh, input logic [6:0] code, input bit dn,
                      input bit pp, input bit pk, input int ofs,
                      input bit cl, input bit ec, input string tag);
    logic [7:0] snap [DEPTH];
    bit irq_e = 1'b0;
    bit ovf_e = 1'b0;
    int old_lvl;
    push_i = psh; key_code_i = code; key_down_i = dn;
    pop_i = pp; peek_i = pk; peek_ofs_i = OFS_W'(ofs);
    clr_i = cl; err_clr_i = ec;
    @(negedge clk);
    snap = mdl;
    old_lvl = m_lvl;
    if (cl) begin
      m_head = 0; m_lvl = 0; m_lock = 1'b0; m_rd = 8'h00;
    end else begin
      if (psh && !m_lock) begin
        if (old_lvl == DEPTH) ovf_e = 1'b1;
        else begin
          mdl[(m_head + old_lvl) % DEPTH] = {dn, code};
          irq_e = 1'b1;
        end
      end
      if (pp) begin
        if (old_lvl > 0) begin
          m_head = (m_head + 1) % DEPTH;
          m_rd   = snap[m_head];
          m_lvl  = m_lvl - 1;
        end else m_rd = 8'h00;
      end else if (pk) begin
        m_rd = (ofs < old_lvl) ? snap[(m_head + ofs) % DEPTH] : 8'h00;
      end
      if (irq_e) m_lvl = m_lvl + 1;
      if (ovf_e) m_lock = 1'b1;
      else if (ec) m_lock = 1'b0;
    end
    chk(tag, "level_o",    int'(level_o),    m_lvl);
    chk(tag, "kp_irq_o",   int'(kp_irq_o),   int'(irq_e));
    chk(tag, "ovf_req_o",  int'(ovf_req_o),  int'(ovf_e));
    chk(tag, "ovf_lock_o", int'(ovf_lock_o), int'(m_lock));
    chk(tag, "rd_data_o",  int'(rd_data_o),  int'(m_rd));
  endtask

  task automatic idle(input string tag);
    step(0, 7'h0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic push(input logic [6:0] code, input bit dn, input string tag);
    step(1, code, dn, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic pop(input string tag);
    step(0, 7'h0, 0, 1, 0, 0, 0, 0, tag);
  endtask

  task automatic peek(input int ofs, input string tag);
    step(0, 7'h0, 0, 0, 1, ofs, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    rst_n = 1'b0;
    clr_i = 0; err_clr_i = 0; push_i = 0; key_down_i = 0; pop_i = 0; peek_i = 0;
    key_code_i = '0; peek_ofs_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle("R1");

    // R5 / R2: five events, alternating press and release
    for (int i = 0; i < 5; i++) push(7'((i * 13 + 3) & 7'h7f), bit'(i % 2), "R5");
    peek(0, "R2");
    for (int n = 1; n < 8; n++) peek(n, "R7");

    // R6: drain by pops, then R9: pops from empty
    for (int i = 0; i < 5; i++) pop("R6");
    pop("R9");
    pop("R9");

    // R11 / R3 / R4: head sits at slot 5, refill so the write position wraps
    for (int i = 0; i < DEPTH; i++) push(7'((i * 29 + 11) & 7'h7f), bit'((i >> 1) & 1), "R11");
    push(7'h3c, 1, "R3");
    for (int i = 0; i < 3; i++) push(7'(i + 40), 0, "R4");
    pop("R4");
    push(7'h55, 1, "R4");
    step(0, 7'h0, 0, 0, 0, 0, 0, 1, "R4");
    push(7'h21, 1, "R4");

    // R7: peek sweep over a full queue and past its end
    for (int n = 0; n < 21; n++) peek(n, "R7");

    // R10: push and pop together, at full and partial levels
    step(1, 7'h12, 1, 1, 0, 0, 0, 0, "R10");
    step(0, 7'h0, 0, 0, 0, 0, 0, 1, "R4");
    for (int i = 0; i < 4; i++) pop("R6");
    for (int i = 0; i < 6; i++) step(1, 7'(i + 90), bit'(i % 2), 1, 0, 0, 0, 0, "R10");
    while (m_lvl > 1) pop("R6");
    step(1, 7'h6e, 1, 1, 0, 0, 0, 0, "R10");
    step(1, 7'h6f, 0, 1, 0, 0, 0, 0, "R10");

    // R8: clear overrides a push in the same cycle, and releases the lock
    push(7'h01, 1, "R5");
    step(1, 7'h02, 1, 0, 0, 0, 1, 0, "R8");
    peek(0, "R8");
    for (int i = 0; i < DEPTH + 1; i++) push(7'(i + 60), 1, "R3");
    step(0, 7'h0, 0, 0, 1, 0, 1, 0, "R8");
    push(7'h44, 0, "R8");
    peek(0, "R8");

    // R11: long arithmetic mix of operations
    for (int i = 0; i < 240; i++) begin
      int op;
      op = (i * 7 + 3) % 5;
      case (op)
        0, 1: step(1, 7'((i * 37) & 7'h7f), bit'(i % 3 == 0), 0, 0, 0, 0, i % 37 == 0, "R11");
        2:    pop("R11");
        3:    peek(i % 18, "R11");
        default: step(1, 7'((i * 11) & 7'h7f), bit'(i % 2), 1, 0, 0, 0, 0, "R11");
      endcase
    end
    idle("R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule